// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

This unit reads each 64-bit operand as a square bit matrix with eight rows of eight bits. Byte r of a word is row r, and bit c of that byte is the element in column c. Three operations are available. A transpose acts on the first operand alone. A product over GF(2) combines the element products with XOR. A Boolean product combines them with OR. In both products, rows of the first operand are combined with columns of the second.

The operation is chosen per request by a 2-bit code. A request is presented with a valid strobe. The answer appears one clock later from a single output register, and a new request can be accepted on every cycle. When no request is presented, the output register keeps its last value.

Top module: `bitmat_unit`

## Requirements
- R1: While reset is asserted, `res_valid` is 0 and `res_data` is 0.
- R2: Code 2'b00 (transpose): the result bit at position 8*c+r equals `opnd_a` bit 8*r+c. `opnd_b` has no effect on the result.
- R3: Code 2'b01 (XOR product): result bit 8*r+c is the parity of the set of k for which both `opnd_a` bit 8*r+k and `opnd_b` bit 8*k+c are 1.
- R4: Code 2'b10 (OR product): result bit 8*r+c is 1 exactly when some k has both `opnd_a` bit 8*r+k and `opnd_b` bit 8*k+c set to 1.
- R5: Code 2'b11 is reserved and returns a result of all zeros.
- R6: With either product code, an identity operand 0x8040201008040201 on one side returns the other operand unchanged.
- R7: A request accepted on a clock edge raises `res_valid` for exactly the following cycle and carries its result in that cycle. Back-to-back requests produce one result per cycle.
- R8: In a cycle after a clock edge at which `req_valid` was low, `res_valid` is 0 and `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| op_code | input | 2 | 00 transpose, 01 XOR product, 10 OR product, 11 reserved |
| opnd_a | input | 64 | First matrix; rows are bytes |
| opnd_b | input | 64 | Second matrix; rows are bytes |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 64 | Registered result matrix |

## Verification
Two things can collide at the output register in a single cycle: the result of the previous request being presented, and the capture of a new request. A stream of requests arrives on consecutive cycles with the operation code rotating every cycle, so each result is checked while the next request is already being captured. Idle cycles are inserted at intervals to exercise the other branch, where the register must hold its value and drop `res_valid`. Each presented word is compared with a model in the bench that computes the matrix entries element by element.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;
  typedef enum logic [1:0] {
    BM_FLIP = 2'b00,
    BM_MXOR = 2'b01,
    BM_MOR  = 2'b10,
    BM_RSVD = 2'b11
  } bm_op_e;
endpackage

// File: rtl/bitmat_transpose.sv
module bitmat_transpose #(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic [W-1:0] m_in,
  output logic [W-1:0] m_out
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign m_out[c*DIM + r] = m_in[r*DIM + c];
    end
  end
endmodule

// File: rtl/bitmat_mult.sv
module bitmat_mult #(
  parameter int DIM    = 8,
  parameter bit USE_OR = 1'b0,
  localparam int W = DIM * DIM
) (
  input  logic [W-1:0] mat_a,
  input  logic [W-1:0] cols_b,
  output logic [W-1:0] prod
);
  // combine one row with one column
  function automatic logic dot(input logic [DIM-1:0] u, input logic [DIM-1:0] v);
    if (USE_OR) return |(u & v);
    else        return ^(u & v);
  endfunction

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign prod[r*DIM + c] = dot(mat_a[r*DIM +: DIM], cols_b[c*DIM +: DIM]);
    end
  end
endmodule

// File: rtl/bitmat_unit.sv
module bitmat_unit #(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  import bitmat_pkg::*;

  function automatic logic [W-1:0] make_ident();
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < DIM; i++) m[i*DIM + i] = 1'b1;
    return m;
  endfunction
  localparam logic [W-1:0] IDENT = make_ident();

  logic [W-1:0] flip_a_w;
  logic [W-1:0] cols_b_w;
  logic [W-1:0] prod_w [2];
  logic [W-1:0] next_res_w;
  bm_op_e       op_w;

  assign op_w = bm_op_e'(op_code);

  bitmat_transpose #(.DIM(DIM)) u_flip_a (.m_in(opnd_a), .m_out(flip_a_w));
  bitmat_transpose #(.DIM(DIM)) u_cols_b (.m_in(opnd_b), .m_out(cols_b_w));

  for (genvar g = 0; g < 2; g++) begin : g_prod
    bitmat_mult #(.DIM(DIM), .USE_OR(g == 1)) u_mult (
      .mat_a (opnd_a),
      .cols_b(cols_b_w),
      .prod  (prod_w[g])
    );
  end

  always_comb begin
    case (op_w)
      BM_FLIP: next_res_w = flip_a_w;
      BM_MXOR: next_res_w = prod_w[0];
      BM_MOR:  next_res_w = prod_w[1];
      default: next_res_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_data <= next_res_w;
    end
  end

  AST_FLIP_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op_code == 2'b00 |=> $countones(res_data) == $countones($past(opnd_a))); // R2
  AST_XOR_ZERO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op_code == 2'b01 && opnd_a == '0 |=> res_data == '0); // R3
  AST_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op_code == 2'b10 && (opnd_a == '0 || opnd_b == '0) |=> res_data == '0); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op_code == 2'b11 |=> res_data == '0); // R5
  AST_IDENT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (op_code == 2'b01 || op_code == 2'b10) && opnd_a == IDENT
    |=> res_data == $past(opnd_b)); // R6
  AST_IDENT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (op_code == 2'b01 || op_code == 2'b10) && opnd_b == IDENT
    |=> res_data == $past(opnd_a)); // R6
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && $stable(res_data)); // R8
endmodule

// File: tb/bitmat_unit_bench.sv
`timescale 1ns/1ps
module bitmat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  op_code;
  logic [63:0] opnd_a, opnd_b;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] ID8 = 64'h8040201008040201;

  always #4 clk = ~clk;

  bitmat_unit u_bitmat_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] m;
    logic acc;
    m = '0;
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        if (op == 2'b00) m[c*8 + r] = a[r*8 + c];
        else if (op != 2'b11) begin
          acc = 1'b0;
          for (int k = 0; k < 8; k++) begin
            if (op == 2'b01) acc = acc ^ (a[r*8 + k] & b[k*8 + c]);
            else             acc = acc | (a[r*8 + k] & b[k*8 + c]);
          end
          m[r*8 + c] = acc;
        end
      end
    end
    return m;
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    logic        pend;
    logic [63:0] pend_exp;
    string       pend_tag;
    logic [63:0] last_res;
    seed = 64'h0123456789ABCDEF;
    rst_n = 1'b0; req_valid = 1'b0; op_code = 2'b00; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", {63'b0, res_valid}, 64'd0);
    check("R1 data", res_data, 64'd0);
    rst_n = 1'b1;
    pend = 1'b0; pend_exp = '0; pend_tag = ""; last_res = '0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (pend) begin
        check({pend_tag, " R7 valid"}, {63'b0, res_valid}, 64'd1);
        check(pend_tag, res_data, pend_exp);
        last_res = pend_exp;
      end else if (n > 0) begin
        check("R8 valid", {63'b0, res_valid}, 64'd0);
        check("R8 hold", res_data, last_res);
      end
      if (n % 7 == 6 || n == 399) begin
        req_valid = 1'b0;
        seed = xs(seed);
        opnd_a = seed;
        op_code = seed[1:0];
        pend = 1'b0;
      end else begin
        seed = xs(seed);
        op_code = 2'(n % 4);
        opnd_a = (n < 64) ? (64'd1 << n) : seed;
        seed = xs(seed);
        opnd_b = seed;
        if (n % 11 == 5) opnd_a = ID8;
        if (n % 11 == 9) opnd_b = ID8;
        req_valid = 1'b1;
        pend = 1'b1;
        pend_exp = model(op_code, opnd_a, opnd_b);
        case (op_code)
          2'b00: pend_tag = "R2 flip";
          2'b01: pend_tag = "R3 xor";
          2'b10: pend_tag = "R4 or";
          default: pend_tag = "R5 rsvd";
        endcase
        if (op_code == 2'b01 || op_code == 2'b10) begin
          if (opnd_a == ID8) begin
            pend_exp = opnd_b; pend_tag = {pend_tag, " R6 ident-left"};
          end else if (opnd_b == ID8) begin
            pend_exp = opnd_a; pend_tag = {pend_tag, " R6 ident-right"};
          end
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule